// File: doc/BRIEF.md
# RC6-Style Shared Encrypt/Decrypt Round Engine

This block is an iterative 128-bit block cipher engine of the RC6 family. It treats a block as four 32-bit words A, B, C and D. One combinational step unit does both encryption and decryption, and a mode input chosen at start picks the direction. A table of 44 round keys is filled ahead of time through a small write port. Generating the keys from a user key is left to other logic. The table holds the schedule for a 128-bit user key.

A run is started by a one-cycle start pulse while the engine is idle. The engine then spends one clock on the input whitening step, 20 clocks on the rounds (one round per clock) and one clock on the output whitening step. It then raises done for a single cycle. The result stays on the output until the next accepted start. While a block is in flight, a start pulse has no effect and writes to the key table have no effect.

Top module: `rc6e_engine`

## Requirements
- R1: Word packing is A = bits [31:0], B = [63:32], C = [95:64], D = [127:96] for both blk_in and blk_out. With f(x) = (x*(2x+1) mod 2^32) rotated left by 5, encryption computes B+=S0 and D+=S1. It then runs 20 rounds, i = 1 to 20, each setting A=rotl(A^f(B), f(D)[4:0])+S[2i] and C=rotl(C^f(D), f(B)[4:0])+S[2i+1] and then turning (A,B,C,D) into (B,C,D,A). It finishes with A+=S42 and C+=S43.
- R2: With decrypt high at start, the engine computes the exact inverse of R1, so decrypting a ciphertext under the same key table returns the plaintext.
- R3: A run lasts exactly 22 clocks. busy is high from the accepting edge until the 22nd rising edge after it. done is first high in the cycle after that 22nd edge, and done is never high while busy is high.
- R4: done is high for exactly one cycle per run.
- R5: While idle and with no start, blk_out keeps its value whatever blk_in and decrypt do.
- R6: A start pulse while busy is ignored: the run in flight keeps its data, mode and timing.
- R7: A key write with key_we high at an address below 44 updates that entry when the engine is idle. It has no effect while busy.
- R8: After reset, busy and done are low, blk_out is zero and every key entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_we | input | 1 | Round-key write strobe |
| key_addr | input | 6 | Round-key entry index (0 to 43) |
| key_data | input | 32 | Round-key value to write |
| start | input | 1 | Begin a block when idle |
| decrypt | input | 1 | Direction at start: 1 decrypt, 0 encrypt |
| blk_in | input | 128 | Input block, word A in the low bits |
| blk_out | output | 128 | Result block, held until next start |
| busy | output | 1 | A block is in flight |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start and key_we are driven synchronously and held stable around each rising edge. They also assume that rst_n is asserted long enough to clear the key table before any run begins. The bench changes every input only on the falling clock edge, and it loads the key table only after reset has been released. It also deliberately raises start and key_we in the middle of a run, so that the ignore rules face live stimulus rather than being left unexercised.

// File: rtl/rc6e_pkg.sv
package rc6e_pkg;
  localparam int WORD_W = 32;
  localparam int LOG_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LOG_W-1:0]  shamt_t;

  typedef struct packed {
    word_t d;
    word_t c;
    word_t b;
    word_t a;
  } blk_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_RND  = 2'd2,
    PH_POST = 2'd3
  } phase_e;

  function automatic word_t rotl(input word_t x, input shamt_t s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << s;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t rotr(input word_t x, input shamt_t s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} >> s;
    return dbl[WORD_W-1:0];
  endfunction

  // quadratic mixing word: x*(2x+1), then rotate by log2 of word width
  function automatic word_t mix(input word_t x);
    word_t prod;
    prod = x * {x[WORD_W-2:0], 1'b1};
    return rotl(prod, shamt_t'(LOG_W));
  endfunction
endpackage

// File: rtl/rc6e_keybank.sv
module rc6e_keybank import rc6e_pkg::*; #(
  parameter int NKEYS = 44,
  localparam int KAW  = $clog2(NKEYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic                   lock,
  input  logic [KAW-1:0]         waddr,
  input  word_t                  wdata,
  input  logic [KAW-1:0]         ra_lo,
  input  logic [KAW-1:0]         ra_hi,
  output word_t                  rd_lo,
  output word_t                  rd_hi,
  output logic [NKEYS*WORD_W-1:0] tbl_flat
);
  word_t tbl [NKEYS];

  logic waddr_ok, ra_lo_ok, ra_hi_ok;
  assign waddr_ok = ({1'b0, waddr} < (KAW+1)'(NKEYS));
  assign ra_lo_ok = ({1'b0, ra_lo} < (KAW+1)'(NKEYS));
  assign ra_hi_ok = ({1'b0, ra_hi} < (KAW+1)'(NKEYS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NKEYS; i++) tbl[i] <= '0;
    end else if (we && !lock && waddr_ok) begin
      tbl[waddr] <= wdata;
    end
  end

  assign rd_lo = ra_lo_ok ? tbl[ra_lo] : '0;
  assign rd_hi = ra_hi_ok ? tbl[ra_hi] : '0;

  for (genvar g = 0; g < NKEYS; g++) begin : g_flat
    assign tbl_flat[g*WORD_W +: WORD_W] = tbl[g];
  end
endmodule

// File: rtl/rc6e_step.sv
module rc6e_step import rc6e_pkg::*; (
  input  phase_e phase,
  input  logic   dec,
  input  blk_t   cur,
  input  word_t  k_lo,
  input  word_t  k_hi,
  output blk_t   nxt
);
  blk_t  enc_rnd, dec_rnd, dec_pre;
  word_t t_e, u_e, t_d, u_d;

  // forward round: mix, then rotate the word order left by one word
  assign t_e = mix(cur.b);
  assign u_e = mix(cur.d);
  always_comb begin
    enc_rnd.a = cur.b;
    enc_rnd.b = rotl(cur.c ^ u_e, shamt_t'(t_e)) + k_hi;
    enc_rnd.c = cur.d;
    enc_rnd.d = rotl(cur.a ^ t_e, shamt_t'(u_e)) + k_lo;
  end

  // inverse round: rotate the word order right first, then unmix
  always_comb begin
    dec_pre.a = cur.d;
    dec_pre.b = cur.a;
    dec_pre.c = cur.b;
    dec_pre.d = cur.c;
  end
  assign t_d = mix(dec_pre.b);
  assign u_d = mix(dec_pre.d);
  always_comb begin
    dec_rnd   = dec_pre;
    dec_rnd.c = rotr(dec_pre.c - k_hi, shamt_t'(t_d)) ^ u_d;
    dec_rnd.a = rotr(dec_pre.a - k_lo, shamt_t'(u_d)) ^ t_d;
  end

  always_comb begin
    nxt = cur;
    unique case (phase)
      PH_PRE: begin
        if (dec) begin
          nxt.a = cur.a - k_lo;
          nxt.c = cur.c - k_hi;
        end else begin
          nxt.b = cur.b + k_lo;
          nxt.d = cur.d + k_hi;
        end
      end
      PH_RND:  nxt = dec ? dec_rnd : enc_rnd;
      PH_POST: begin
        if (dec) begin
          nxt.b = cur.b - k_lo;
          nxt.d = cur.d - k_hi;
        end else begin
          nxt.a = cur.a + k_lo;
          nxt.c = cur.c + k_hi;
        end
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/rc6e_ctrl.sv
module rc6e_ctrl import rc6e_pkg::*; #(
  parameter int ROUNDS = 20,
  localparam int NKEYS = 2*ROUNDS + 4,
  localparam int KAW   = $clog2(NKEYS),
  localparam int CW    = $clog2(ROUNDS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           decrypt,
  output phase_e         phase,
  output logic           mode_q,
  output logic [CW-1:0]  rnd,
  output logic [KAW-1:0] ka_lo,
  output logic [KAW-1:0] ka_hi,
  output logic           busy,
  output logic           accept,
  output logic           done
);
  localparam logic [KAW-1:0] K_TAIL = KAW'(NKEYS - 2);

  logic          last_rnd;
  logic [KAW-1:0] base;

  assign busy     = (phase != PH_IDLE);
  assign accept   = start && !busy;
  assign last_rnd = mode_q ? (rnd == CW'(1)) : (rnd == CW'(ROUNDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      mode_q <= 1'b0;
      rnd    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_PRE;
          mode_q <= decrypt;
          rnd    <= decrypt ? CW'(ROUNDS) : CW'(1);
        end
        PH_PRE: phase <= PH_RND;
        PH_RND: begin
          if (last_rnd) phase <= PH_POST;
          else          rnd   <= mode_q ? rnd - CW'(1) : rnd + CW'(1);
        end
        PH_POST: begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (phase)
      PH_PRE:  base = mode_q ? K_TAIL : '0;
      PH_RND:  base = KAW'({rnd, 1'b0});
      PH_POST: base = mode_q ? '0 : K_TAIL;
      default: base = '0;
    endcase
  end
  assign ka_lo = base;
  assign ka_hi = base | KAW'(1);
endmodule

// File: rtl/rc6e_engine.sv
module rc6e_engine import rc6e_pkg::*; #(
  parameter int ROUNDS = 20,
  localparam int NKEYS = 2*ROUNDS + 4,
  localparam int KAW   = $clog2(NKEYS),
  localparam int CW    = $clog2(ROUNDS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_we,
  input  logic [KAW-1:0]      key_addr,
  input  logic [WORD_W-1:0]   key_data,
  input  logic                start,
  input  logic                decrypt,
  input  logic [4*WORD_W-1:0] blk_in,
  output logic [4*WORD_W-1:0] blk_out,
  output logic                busy,
  output logic                done
);
  phase_e         phase;
  logic           mode_q, accept;
  logic [CW-1:0]  rnd;
  logic [KAW-1:0] ka_lo, ka_hi;
  word_t          k_lo, k_hi;
  blk_t           cur_q, nxt;
  logic [NKEYS*WORD_W-1:0] key_tbl_flat;

  rc6e_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
    .phase(phase), .mode_q(mode_q), .rnd(rnd),
    .ka_lo(ka_lo), .ka_hi(ka_hi),
    .busy(busy), .accept(accept), .done(done)
  );

  rc6e_keybank #(.NKEYS(NKEYS)) u_keys (
    .clk(clk), .rst_n(rst_n), .we(key_we), .lock(busy),
    .waddr(key_addr), .wdata(key_data),
    .ra_lo(ka_lo), .ra_hi(ka_hi), .rd_lo(k_lo), .rd_hi(k_hi),
    .tbl_flat(key_tbl_flat)
  );

  rc6e_step u_step (
    .phase(phase), .dec(mode_q), .cur(cur_q),
    .k_lo(k_lo), .k_hi(k_hi), .nxt(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (accept) cur_q <= blk_t'(blk_in);
    else if (busy)   cur_q <= nxt;
  end

  assign blk_out = cur_q;
endmodule

// File: rtl/rc6e_engine_chk.sv
module rc6e_engine_chk import rc6e_pkg::*; #(
  parameter int ROUNDS = 20,
  localparam int NKEYS = 2*ROUNDS + 4,
  localparam int CW    = $clog2(ROUNDS + 1),
  localparam int STEPS = ROUNDS + 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      busy,
  input logic                      done,
  input logic [4*WORD_W-1:0]       blk_out,
  input logic [NKEYS*WORD_W-1:0]   tbl_flat,
  input logic [CW-1:0]             rnd
);
  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= STEPS);
  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == STEPS);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  assert_rnd_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rnd >= CW'(1) && rnd <= CW'(ROUNDS)));
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(blk_out));
  assert_start_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_key_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tbl_flat));
endmodule

bind rc6e_engine rc6e_engine_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .blk_out(blk_out), .tbl_flat(key_tbl_flat), .rnd(rnd)
);

// File: tb/rc6e_engine_bench.sv
`timescale 1ns/1ps
module rc6e_engine_bench;
  localparam int ROUNDS = 20;
  localparam int NK     = 2*ROUNDS + 4;
  localparam int LAT    = ROUNDS + 3; // falling edges from accept to first done sample

  localparam logic [127:0] VEC [6] = '{
    128'h0,
    128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
    128'h00000001_00000000_00000000_80000000,
    128'h0123CDEF_89AB4567_FEDC3210_76548BA9,
    128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C,
    128'h13579BDF_2468ACE0_0F1E2D3C_4B5A6978
  };

  logic         clk = 0;
  logic         rst_n;
  logic         key_we;
  logic [5:0]   key_addr;
  logic [31:0]  key_data;
  logic         start, decrypt;
  logic [127:0] blk_in, blk_out;
  logic         busy, done;

  int checks = 0;
  int fails  = 0;
  logic [31:0] kt [NK];

  always #2 clk = ~clk;

  rc6e_engine u_rc6e_engine (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_addr(key_addr),
    .key_data(key_data), .start(start), .decrypt(decrypt),
    .blk_in(blk_in), .blk_out(blk_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    int m;
    m = n % 32;
    if (m == 0) return x;
    return (x << m) | (x >> (32 - m));
  endfunction

  function automatic logic [31:0] qf(input logic [31:0] x);
    logic [31:0] y;
    y = x * (x + x + 32'd1);
    return rl(y, 5);
  endfunction

  // independent forward model on a word array with explicit index rotation
  function automatic logic [127:0] ref_enc(input logic [127:0] p);
    logic [31:0] w [4];
    logic [31:0] t, u, tmp;
    for (int k = 0; k < 4; k++) w[k] = p[32*k +: 32];
    w[1] = w[1] + kt[0];
    w[3] = w[3] + kt[1];
    for (int i = 1; i <= ROUNDS; i++) begin
      t = qf(w[1]);
      u = qf(w[3]);
      w[0] = rl(w[0] ^ t, int'(u[4:0])) + kt[2*i];
      w[2] = rl(w[2] ^ u, int'(t[4:0])) + kt[2*i+1];
      tmp = w[0]; w[0] = w[1]; w[1] = w[2]; w[2] = w[3]; w[3] = tmp;
    end
    w[0] = w[0] + kt[NK-2];
    w[2] = w[2] + kt[NK-1];
    return {w[3], w[2], w[1], w[0]};
  endfunction

  task automatic write_key(input int idx, input logic [31:0] val);
    @(negedge clk);
    key_we = 1; key_addr = 6'(idx); key_data = val;
    @(negedge clk);
    key_we = 0;
  endtask

  // one block; optional pokes at the 5th falling edge of the run
  task automatic run(input logic [127:0] din, input logic dec,
                     input bit poke_start, input bit poke_key,
                     output logic [127:0] dout, output int lat);
    @(negedge clk);
    blk_in = din; decrypt = dec; start = 1;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 60) begin
      if (lat == 5) begin
        if (poke_start) begin start = 1; blk_in = ~din; decrypt = ~dec; end
        if (poke_key) begin key_we = 1; key_addr = 6'd3; key_data = 32'hDEADBEEF; end
      end else begin
        start = 0; key_we = 0;
      end
      @(negedge clk);
      lat++;
    end
    start = 0; key_we = 0;
    dout = blk_out;
    @(negedge clk);
    chk(!done, "R4 done pulse width", 128'(done), 128'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] ct, pt, ref_v, held;
    int lat;
    rst_n = 0; key_we = 0; key_addr = 0; key_data = 0;
    start = 0; decrypt = 0; blk_in = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0, "R8 busy after reset", 128'(busy), 128'(0));
    chk(done == 0, "R8 done after reset", 128'(done), 128'(0));
    chk(blk_out == 0, "R8 output after reset", blk_out, 128'(0));
    rst_n = 1;

    // all-zero table: encrypting zero must follow the model with S=0
    for (int i = 0; i < NK; i++) kt[i] = 32'h0;
    run(VEC[3], 0, 0, 0, ct, lat);
    chk(ct == ref_enc(VEC[3]), "R8 zero key table", ct, ref_enc(VEC[3]));

    for (int i = 0; i < NK; i++) begin
      kt[i] = (32'(i) + 32'd1) * 32'h9E3779B9 ^ (32'hB7E15163 >> (i % 7));
      write_key(i, kt[i]);
    end

    for (int v = 0; v < 6; v++) begin
      run(VEC[v], 0, 0, 0, ct, lat);
      ref_v = ref_enc(VEC[v]);
      chk(ct == ref_v, "R1 encrypt vector", ct, ref_v);
      chk(lat == LAT, "R3 encrypt latency", 128'(lat), 128'(LAT));
      run(ct, 1, 0, 0, pt, lat);
      chk(pt == VEC[v], "R2 decrypt round trip", pt, VEC[v]);
      chk(lat == LAT, "R3 decrypt latency", 128'(lat), 128'(LAT));
    end

    // R5: idle output holds while inputs move
    held = blk_out;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      blk_in = {4{32'(k) * 32'h01010101}}; decrypt = k[0];
    end
    chk(blk_out == held, "R5 idle hold", blk_out, held);

    // R6: start pulse mid-run has no effect
    run(VEC[4], 0, 1, 0, ct, lat);
    ref_v = ref_enc(VEC[4]);
    chk(ct == ref_v, "R6 start ignored data", ct, ref_v);
    chk(lat == LAT, "R6 start ignored timing", 128'(lat), 128'(LAT));
    chk(busy == 0, "R6 no restart", 128'(busy), 128'(0));

    // R7: key write mid-run has no effect, now or later
    run(VEC[5], 0, 0, 1, ct, lat);
    ref_v = ref_enc(VEC[5]);
    chk(ct == ref_v, "R7 write while busy", ct, ref_v);
    run(VEC[5], 0, 0, 0, ct, lat);
    chk(ct == ref_v, "R7 table unchanged", ct, ref_v);

    // R7: write while idle takes effect
    kt[7] = 32'h12345678;
    write_key(7, kt[7]);
    run(VEC[2], 0, 0, 0, ct, lat);
    ref_v = ref_enc(VEC[2]);
    chk(ct == ref_v, "R7 idle write applied", ct, ref_v);
    run(ct, 1, 0, 0, pt, lat);
    chk(pt == VEC[2], "R2 round trip new key", pt, VEC[2]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule